// File: doc/BRIEF.md
# Radix-4 Constant-Geometry Twiddle Address Sequencer

This block drives the stage loop and the butterfly loop of a radix-4 constant-geometry number theoretic transform. A transform of N = 4^L points runs L stages. Each stage has N/4 butterflies. On every butterfly the block issues the stage number, the butterfly index and one read address. The three twiddle ROMs (first, second and third power of the stage root) all use that address on the same cycle. The ROMs are filled in digit-reversed order, so the address is used exactly as issued.

A forward run takes the stages upward from 1 to L, with the index counting up from 0. An inverse run takes the stages downward from L to 1, with the index counting down from N/4−1. In both directions the address is the index reduced modulo 4^(s−1) plus a stage base of (4^(s−1)−1)/3. Stage s therefore owns 4^(s−1) consecutive ROM entries, and the entries of all stages together fill (4^L−1)/3 locations.

Top module: `nt_cg_twiddle_agen`

## Requirements
- R1: When `start` is sampled high in idle with a legal `len_log4`, `valid` is high from the next cycle on. The first `stage` is 1 in forward mode (`inverse`=0) and L in inverse mode (`inverse`=1).
- R2: In forward mode, `valid` stays high for L·N/4 consecutive cycles. The stages rise from 1 to L, and within each stage `bfly_idx` counts 0,1,…,N/4−1, one step per cycle.
- R3: In inverse mode, `valid` stays high for L·N/4 consecutive cycles. The stages fall from L to 1, and within each stage `bfly_idx` counts N/4−1 down to 0, one step per cycle.
- R4: While `valid` is high, `rom_addr` = (`bfly_idx` mod 4^(s−1)) + (4^(s−1)−1)/3, where s is `stage`. Stage s addresses therefore stay within [(4^(s−1)−1)/3, (4^s−1)/3).
- R5: `done` is high for exactly one cycle. That cycle is the one right after the last valid butterfly, and `done` is never high together with `valid`.
- R6: During a run, `start` is ignored, and changes to `inverse` and `len_log4` are ignored. The sequence continues unchanged and produces one `done`.
- R7: `start` with `len_log4` equal to 0 or greater than LOG4_MAX is ignored: `valid` and `done` stay low.
- R8: After reset, and whenever `valid` is low, `valid`, `done`, `stage`, `bfly_idx` and `rom_addr` read 0 (apart from the single `done` cycle).
- R9: With `len_log4`=1 (N=4), a run issues exactly one butterfly: stage 1, index 0, address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transform when idle |
| inverse | input | 1 | 0 = forward order, 1 = inverse order |
| len_log4 | input | STG_W (3) | L = log4 of transform length |
| valid | output | 1 | A butterfly is issued this cycle |
| done | output | 1 | One-cycle pulse after the final butterfly |
| stage | output | STG_W (3) | Current stage number s (1..L) |
| bfly_idx | output | IDX_W (8) | Butterfly index used for this cycle |
| rom_addr | output | ADDR_W (9) | Shared address for the three twiddle ROMs |

## Verification
The bench compares every issued butterfly against a reference loop. It covers every legal length from N=4 to N=1024 in both directions. The stage boundaries are the main target: an off-by-one stage base, or a residue mask one digit too wide, would move every address of a stage into its neighbour's entries. Inverse runs catch a design that reverses the stages but not the index, or that reverses the index before reducing it. Further runs restart with `start` asserted mid-run while the mode and length inputs change, and issue starts with illegal lengths. A design that reloaded its counters, or that started on a zero length, would show extra valid cycles or a stray `done`.

// File: rtl/nt_cg_pkg.sv
package nt_cg_pkg;

    typedef enum logic { DIR_FWD = 1'b0, DIR_INV = 1'b1 } dir_e;

    typedef enum logic { ST_IDLE = 1'b0, ST_RUN = 1'b1 } run_state_e;

    // First ROM entry of stage s: (4^(s-1)-1)/3; 0 for s <= 0.
    function automatic int stage_base(input int s);
        if (s <= 0) return 0;
        return ((1 << (2 * (s - 1))) - 1) / 3;
    endfunction

    // Mask that reduces an index modulo 4^(s-1); 0 for s <= 0.
    function automatic int stage_mask(input int s);
        if (s <= 0) return 0;
        return (1 << (2 * (s - 1))) - 1;
    endfunction

    function automatic int max1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/nt_cg_seq.sv
module nt_cg_seq
    import nt_cg_pkg::*;
#(
    parameter int LOG4_MAX = 5,
    parameter int STG_W    = 3,
    parameter int IDX_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  dir_e             dir_in,
    input  logic [STG_W-1:0] len_in,
    output logic             run,
    output logic             done,
    output dir_e             dir_q,
    output logic [STG_W-1:0] stage_q,
    output logic [IDX_W-1:0] cnt_q,
    output logic [IDX_W-1:0] last_i
);

    run_state_e       state_q;
    logic [STG_W-1:0] len_q;
    logic             done_q;
    logic             len_ok;
    logic             stage_end;
    logic             final_stage;
    logic [STG_W-1:0] fin_stage;

    assign len_ok    = (len_in != '0) && (len_in <= STG_W'(LOG4_MAX));
    assign last_i    = IDX_W'(stage_mask(int'(len_q)));
    assign fin_stage = (dir_q == DIR_INV) ? STG_W'(1) : len_q;
    assign stage_end = (cnt_q == last_i);
    assign final_stage = stage_end && (stage_q == fin_stage);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dir_q   <= DIR_FWD;
            len_q   <= '0;
            stage_q <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start && len_ok) begin
                        state_q <= ST_RUN;
                        dir_q   <= dir_in;
                        len_q   <= len_in;
                        stage_q <= (dir_in == DIR_INV) ? len_in : STG_W'(1);
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (final_stage) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        cnt_q   <= '0;
                        stage_q <= '0;
                    end else if (stage_end) begin
                        cnt_q   <= '0;
                        stage_q <= (dir_q == DIR_INV) ? stage_q - STG_W'(1)
                                                      : stage_q + STG_W'(1);
                    end else begin
                        cnt_q <= cnt_q + IDX_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign run  = (state_q == ST_RUN);
    assign done = done_q;

    // R5: done lasts a single cycle and never coincides with a butterfly
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_excl_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !run);

    // R2 R3: inside a stage the counter advances by one per cycle
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && stage_q == $past(stage_q))
            |-> cnt_q == $past(cnt_q) + IDX_W'(1));

    // R2 R3: a stage change moves by exactly one and restarts the counter
    assert_stage_step_R3: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && stage_q != $past(stage_q))
            |-> ((stage_q == $past(stage_q) + STG_W'(1)) ||
                 (stage_q == $past(stage_q) - STG_W'(1))) && cnt_q == '0);

    // R6: mode and length stay frozen for the whole run
    assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> $stable(dir_q) && $stable(len_q));

endmodule

// File: rtl/nt_cg_addr.sv
module nt_cg_addr
    import nt_cg_pkg::*;
#(
    parameter int LOG4_MAX = 5,
    parameter int STG_W    = 3,
    parameter int IDX_W    = 8,
    parameter int ADDR_W   = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  dir_e              dir,
    input  logic [STG_W-1:0]  stage,
    input  logic [IDX_W-1:0]  cnt,
    input  logic [IDX_W-1:0]  last_i,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);

    localparam int AW1 = ADDR_W + 1;

    logic [AW1-1:0]   base_tab [0:LOG4_MAX+1];
    logic [IDX_W-1:0] mask_tab [0:LOG4_MAX+1];

    // Per-stage base offset and residue mask, one entry per stage number.
    for (genvar g = 0; g <= LOG4_MAX + 1; g++) begin : g_stage_tab
        assign base_tab[g] = AW1'(stage_base(g));
        assign mask_tab[g] = IDX_W'(stage_mask(g));
    end

    logic [IDX_W-1:0] idx_raw;
    logic [AW1-1:0]   addr_raw;

    assign idx_raw  = (dir == DIR_INV) ? (last_i - cnt) : cnt;
    assign addr_raw = AW1'(idx_raw & mask_tab[stage]) + base_tab[stage];

    assign idx  = valid ? idx_raw : '0;
    assign addr = valid ? addr_raw[ADDR_W-1:0] : '0;

    // R4: each address lies inside the slice owned by its stage
    assert_addr_slice_R4: assert property (@(posedge clk) disable iff (rst)
        valid |-> ({1'b0, addr} >= base_tab[stage]) &&
                  ({1'b0, addr} <  base_tab[stage + STG_W'(1)]));

    // R3: the index never leaves the range of the latched length
    assert_idx_bound_R3: assert property (@(posedge clk) disable iff (rst)
        valid |-> idx <= last_i);

endmodule

// File: rtl/nt_cg_twiddle_agen.sv
module nt_cg_twiddle_agen
    import nt_cg_pkg::*;
#(
    parameter int LOG4_MAX = 5,
    localparam int STG_W   = max1($clog2(LOG4_MAX + 1)),
    localparam int IDX_W   = max1(2 * LOG4_MAX - 2),
    localparam int ADDR_W  = max1($clog2(stage_base(LOG4_MAX + 1)))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              inverse,
    input  logic [STG_W-1:0]  len_log4,
    output logic              valid,
    output logic              done,
    output logic [STG_W-1:0]  stage,
    output logic [IDX_W-1:0]  bfly_idx,
    output logic [ADDR_W-1:0] rom_addr
);

    logic             run;
    dir_e             dir_q;
    logic [STG_W-1:0] stage_q;
    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] last_i;

    nt_cg_seq #(
        .LOG4_MAX (LOG4_MAX),
        .STG_W    (STG_W),
        .IDX_W    (IDX_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .dir_in  (dir_e'(inverse)),
        .len_in  (len_log4),
        .run     (run),
        .done    (done),
        .dir_q   (dir_q),
        .stage_q (stage_q),
        .cnt_q   (cnt_q),
        .last_i  (last_i)
    );

    nt_cg_addr #(
        .LOG4_MAX (LOG4_MAX),
        .STG_W    (STG_W),
        .IDX_W    (IDX_W),
        .ADDR_W   (ADDR_W)
    ) u_addr (
        .clk    (clk),
        .rst    (rst),
        .valid  (run),
        .dir    (dir_q),
        .stage  (stage_q),
        .cnt    (cnt_q),
        .last_i (last_i),
        .idx    (bfly_idx),
        .addr   (rom_addr)
    );

    assign valid = run;
    assign stage = run ? stage_q : '0;

endmodule

// File: tb/sim_nt_cg_twiddle_agen.sv
module sim_nt_cg_twiddle_agen;

    localparam int OBS_W = 22;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       inverse = 1'b0;
    logic [2:0] len_log4 = 3'd0;
    logic       valid;
    logic       done;
    logic [2:0] stage;
    logic [7:0] bfly_idx;
    logic [8:0] rom_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    nt_cg_twiddle_agen u0 (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .inverse  (inverse),
        .len_log4 (len_log4),
        .valid    (valid),
        .done     (done),
        .stage    (stage),
        .bfly_idx (bfly_idx),
        .rom_addr (rom_addr)
    );

    function automatic logic [OBS_W-1:0] pack(input logic v, input logic d,
        input int s, input int i, input int a);
        return {v, d, 3'(s), 8'(i), 9'(a)};
    endfunction

    task automatic chk(input string req, input logic [OBS_W-1:0] exp);
        logic [OBS_W-1:0] act;
        act = {valid, done, stage, bfly_idx, rom_addr};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One full transform compared against a reference loop.
    task automatic run_case(input int L, input bit inv, input bit disturb);
        int quarter;
        int k;
        quarter = (1 << (2 * L)) / 4;
        k = 0;
        @(negedge clk);
        inverse  = inv;
        len_log4 = 3'(L);
        start    = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        for (int n = 0; n < L; n++) begin
            int s;
            s = inv ? (L - n) : (n + 1);
            for (int i = 0; i < quarter; i++) begin
                int idx;
                int span;
                idx  = inv ? (quarter - 1 - i) : i;
                span = 1 << (2 * (s - 1));
                if (k > 0) begin
                    @(posedge clk); #1;
                end
                if (k == 0)
                    chk(inv ? "R1 R3 first butterfly" : "R1 R2 first butterfly",
                        pack(1, 0, s, idx, (idx % span) + (span - 1) / 3));
                else if (L == 1)
                    chk("R9 single butterfly", pack(1, 0, s, idx, 0));
                else
                    chk(inv ? "R3 R4 inverse step" : "R2 R4 forward step",
                        pack(1, 0, s, idx, (idx % span) + (span - 1) / 3));
                if (disturb && k == 3) begin
                    start    = 1'b1;
                    inverse  = ~inv;
                    len_log4 = 3'(L == 1 ? 2 : 1);
                end
                if (disturb && k == 4)
                    start = 1'b0;
                k++;
            end
        end
        start = 1'b0;
        @(posedge clk); #1;
        chk("R5 done pulse after last butterfly", pack(0, 1, 0, 0, 0));
        @(posedge clk); #1;
        chk(disturb ? "R6 single done after disturbed run" : "R5 R8 back to idle",
            pack(0, 0, 0, 0, 0));
    endtask

    task automatic bad_len(input int L);
        @(negedge clk);
        len_log4 = 3'(L);
        start    = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        for (int c = 0; c < 4; c++) begin
            chk("R7 illegal length ignored", pack(0, 0, 0, 0, 0));
            @(posedge clk); #1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R8 reset state", pack(0, 0, 0, 0, 0));
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R8 idle after reset", pack(0, 0, 0, 0, 0));

        for (int L = 1; L <= 5; L++) begin
            run_case(L, 1'b0, 1'b0);
            run_case(L, 1'b1, 1'b0);
        end
        run_case(3, 1'b0, 1'b1);
        run_case(4, 1'b1, 1'b1);
        run_case(1, 1'b1, 1'b1);
        bad_len(0);
        bad_len(6);
        bad_len(7);
        run_case(2, 1'b0, 1'b0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule